// File: doc/BRIEF.md
# Burst-Mode Pulse Rate Limiter

This block sits between the pulse inputs of a multi-channel pulse board and its output pulse generators. Each channel presents a one-cycle request strobe. The block either passes the request on as a one-cycle go pulse or drops it, so that the output stage never repeats pulses faster than it can safely sustain. The limits depend on a shared pulse-width switch (long or short output pulses) and on a six-bit board version code.

Two limits apply to every channel. The first is a hard minimum spacing between accepted pulses. The second is a burst budget, modelled as a leaky counter: each accepted pulse adds a weight, and the counter drains by one unit at a fixed period. A short high-rate burst therefore passes, and the block starts dropping pulses once the budget is spent. The burst budget and the faster spacings are used only when the version code shows version 4 or later. On older boards the slow continuous spacing always applies.

Every rejection sets a sticky per-channel error bit. There is one bit vector for frequency-limit rejections and one for burst-budget rejections. A host clears the bits by writing ones to them.

Top module: `brl_rate_limiter`

## Requirements
- R1: After synchronous reset, all go pulses and error bits are 0, the burst counters are empty, and the first request on any channel is accepted.
- R2: An accepted request at clock edge k produces a one-cycle high on that channel's go output after edge k. A rejected or absent request leaves it low.
- R3: A request is rejected unless at least G cycles have passed since that channel's last accepted request. Requests d cycles apart pass when d >= G. G is GAP_SHORT for short pulses and GAP_LONG for long pulses while burst mode is enabled.
- R4: Burst mode is enabled exactly when the upper four bits of the version code [5:2] are 4 or more. When it is disabled, G is GAP_CONT for both pulse widths and no burst-budget rejection occurs.
- R5: With burst mode enabled, each channel keeps a level L. An accepted request adds W: WT_SHORT when the switch input is 1 (short pulses) and WT_LONG when it is 0. L falls by 1, if it is nonzero, on each drain tick. A drain tick is generated when a shared prescaler reaches DRAIN_SHORT-1 or DRAIN_LONG-1 (chosen by the switch) and then restarts from 0. A request that passes R3 is rejected when L+W exceeds TH_SHORT or TH_LONG, matching the switch.
- R6: A request rejected by R3 sets bit c of the frequency-limit error vector, where bit 0 is the first channel. The spacing check takes priority, so the same request never also sets the burst error.
- R7: A request rejected by the burst budget sets bit c of the burst error vector.
- R8: When the write strobe is high, each error bit whose write-data bit is 1 clears. Bits written with 0 keep their value.
- R9: An error being set on the same cycle as a clear of that bit leaves the bit at 1.
- R10: Channels are independent. A request, acceptance or rejection on one channel has no effect on another channel's decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_req_i | input | NCH | Per-channel request strobes |
| short_sel_i | input | 1 | 1 selects short output pulses, 0 selects long pulses |
| hw_code_i | input | 6 | Board version code: [5:2] version, [1:0] revision |
| err_wr_i | input | 1 | Error clear write strobe |
| flim_w1c_i | input | NCH | Write-one-to-clear data for the frequency-limit errors |
| fwdg_w1c_i | input | NCH | Write-one-to-clear data for the burst errors |
| pulse_go_o | output | NCH | Accepted request pulses |
| flim_err_o | output | NCH | Sticky frequency-limit error bits |
| fwdg_err_o | output | NCH | Sticky burst-budget error bits |

## Verification
The bench builds the block with two channels and tiny limits: a continuous spacing of 8 cycles, burst spacings of 4 and 2 cycles, weights of 4 and 3, thresholds of 12 and 9, and drain periods of 5 and 3. With these values the burst budget runs out within a few dozen cycles. This lets the bench sweep all 64 version codes with both switch settings. Dense, sparse, periodic and back-to-back request patterns, mixed with random clears, drive the block into budget exhaustion, draining, and spacing violations in every mode.

// File: rtl/brl_pkg.sv
package brl_pkg;

    // Output pulse width chosen by the board switch
    typedef enum logic {
        PW_LONG  = 1'b0,
        PW_SHORT = 1'b1
    } pw_e;

    // Per-request verdict inside a channel
    typedef enum logic [1:0] {
        DEC_IDLE   = 2'd0,
        DEC_PASS   = 2'd1,
        DEC_GAP    = 2'd2,
        DEC_BUDGET = 2'd3
    } dec_e;

    // Budget settings for one pulse width
    typedef struct packed {
        logic [31:0] weight;
        logic [31:0] thresh;
    } budget_t;

    localparam logic [3:0] BURST_MIN_VER = 4'd4;

    function automatic logic burst_ok(input logic [5:0] code);
        return code[5:2] >= BURST_MIN_VER;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned pick_gap(input logic burst, input pw_e pw,
                                             input int unsigned g_cont,
                                             input int unsigned g_long,
                                             input int unsigned g_short);
        if (!burst) return g_cont;
        return (pw == PW_SHORT) ? g_short : g_long;
    endfunction

    function automatic budget_t pick_budget(input pw_e pw,
                                            input budget_t b_long,
                                            input budget_t b_short);
        return (pw == PW_SHORT) ? b_short : b_long;
    endfunction

endpackage

// File: rtl/brl_drain_tick.sv
module brl_drain_tick
    import brl_pkg::*;
#(
    parameter int unsigned P_LONG  = 3000,
    parameter int unsigned P_SHORT = 1200
) (
    input  logic clk,
    input  logic rst,
    input  pw_e  pw_i,
    output logic tick_o
);
    localparam int unsigned P_MAX = max2(P_LONG, P_SHORT);
    localparam int unsigned CW    = (P_MAX > 1) ? $clog2(P_MAX) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last   = (pw_i == PW_SHORT) ? CW'(P_SHORT - 1) : CW'(P_LONG - 1);
        tick_o = (cnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/brl_sticky.sv
module brl_sticky #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         wr_i,
    input  logic [N-1:0] w1c_i,
    output logic [N-1:0] err_o
);
    logic [N-1:0] clr;

    always_comb clr = wr_i ? w1c_i : '0;

    always_ff @(posedge clk) begin
        if (rst) err_o <= '0;
        else     err_o <= (err_o & ~clr) | set_i;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((err_o & $past(set_i)) == $past(set_i)));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && ((w1c_i & ~set_i) != '0)) |=> ((err_o & $past(w1c_i & ~set_i)) == '0));

endmodule

// File: rtl/brl_chan.sv
module brl_chan
    import brl_pkg::*;
#(
    parameter int unsigned GAP_MAX = 24038,
    parameter int unsigned LVL_MAX = 2048,
    parameter int unsigned SW      = 15,
    parameter int unsigned LW      = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic          burst_i,
    input  logic          tick_i,
    input  logic [SW-1:0] gap_i,
    input  logic [LW-1:0] wt_i,
    input  logic [LW-1:0] th_i,
    output logic          pass_o,
    output logic          flim_set_o,
    output logic          fwdg_set_o
);
    logic [SW-1:0] since_q, since_d;
    logic [LW-1:0] lvl_q, lvl_d;
    dec_e          dec;
    logic          accept;

    // Verdict: spacing first, then budget
    always_comb begin
        dec = DEC_IDLE;
        if (req_i) begin
            if (since_q < gap_i)                          dec = DEC_GAP;
            else if (burst_i && ((lvl_q + wt_i) > th_i))  dec = DEC_BUDGET;
            else                                          dec = DEC_PASS;
        end
        accept     = (dec == DEC_PASS);
        flim_set_o = (dec == DEC_GAP);
        fwdg_set_o = (dec == DEC_BUDGET);
    end

    // Spacing counter saturates at the largest gap
    always_comb begin
        if (accept)                        since_d = SW'(1);
        else if (since_q >= SW'(GAP_MAX))  since_d = since_q;
        else                               since_d = since_q + 1'b1;
    end

    // Leaky level
    always_comb begin
        lvl_d = lvl_q;
        if (tick_i && (lvl_q != '0)) lvl_d = lvl_d - 1'b1;
        if (accept && burst_i)       lvl_d = lvl_d + wt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= SW'(GAP_MAX);
            lvl_q   <= '0;
            pass_o  <= 1'b0;
        end else begin
            since_q <= since_d;
            lvl_q   <= lvl_d;
            pass_o  <= accept;
        end
    end

    // R2
    pass_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> $past(req_i));

    // R3
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pass_o && req_i && (gap_i > SW'(1))) |-> flim_set_o);

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LW'(LVL_MAX));

endmodule

// File: rtl/brl_rate_limiter.sv
module brl_rate_limiter
    import brl_pkg::*;
#(
    parameter int unsigned NCH         = 4,
    parameter int unsigned GAP_CONT    = 24038,
    parameter int unsigned GAP_LONG    = 12000,
    parameter int unsigned GAP_SHORT   = 1000,
    parameter int unsigned WT_LONG     = 8,
    parameter int unsigned WT_SHORT    = 2,
    parameter int unsigned TH_LONG     = 2048,
    parameter int unsigned TH_SHORT    = 2048,
    parameter int unsigned DRAIN_LONG  = 3000,
    parameter int unsigned DRAIN_SHORT = 1200
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pulse_req_i,
    input  logic           short_sel_i,
    input  logic [5:0]     hw_code_i,
    input  logic           err_wr_i,
    input  logic [NCH-1:0] flim_w1c_i,
    input  logic [NCH-1:0] fwdg_w1c_i,
    output logic [NCH-1:0] pulse_go_o,
    output logic [NCH-1:0] flim_err_o,
    output logic [NCH-1:0] fwdg_err_o
);
    localparam int unsigned GAP_MAX = max2(GAP_CONT, max2(GAP_LONG, GAP_SHORT));
    localparam int unsigned SW      = $clog2(GAP_MAX + 1);
    localparam int unsigned TH_MAX  = max2(TH_LONG, TH_SHORT);
    localparam int unsigned WT_MAX  = max2(WT_LONG, WT_SHORT);
    localparam int unsigned LW      = $clog2(TH_MAX + WT_MAX + 1);
    localparam budget_t     B_LONG  = '{weight: WT_LONG,  thresh: TH_LONG};
    localparam budget_t     B_SHORT = '{weight: WT_SHORT, thresh: TH_SHORT};

    pw_e           pw;
    logic          burst;
    budget_t       bud;
    logic [SW-1:0] gap_sel;
    logic [LW-1:0] wt_sel, th_sel;
    logic          tick;
    logic [NCH-1:0] flim_set, fwdg_set;

    always_comb begin
        pw      = pw_e'(short_sel_i);
        burst   = burst_ok(hw_code_i);
        gap_sel = SW'(pick_gap(burst, pw, GAP_CONT, GAP_LONG, GAP_SHORT));
        bud     = pick_budget(pw, B_LONG, B_SHORT);
        wt_sel  = LW'(bud.weight);
        th_sel  = LW'(bud.thresh);
    end

    brl_drain_tick #(
        .P_LONG (DRAIN_LONG),
        .P_SHORT(DRAIN_SHORT)
    ) i_tick (
        .clk   (clk),
        .rst   (rst),
        .pw_i  (pw),
        .tick_o(tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        brl_chan #(
            .GAP_MAX(GAP_MAX),
            .LVL_MAX(TH_MAX),
            .SW     (SW),
            .LW     (LW)
        ) i_chan (
            .clk       (clk),
            .rst       (rst),
            .req_i     (pulse_req_i[c]),
            .burst_i   (burst),
            .tick_i    (tick),
            .gap_i     (gap_sel),
            .wt_i      (wt_sel),
            .th_i      (th_sel),
            .pass_o    (pulse_go_o[c]),
            .flim_set_o(flim_set[c]),
            .fwdg_set_o(fwdg_set[c])
        );
    end

    brl_sticky #(.N(NCH)) i_flim (
        .clk  (clk),
        .rst  (rst),
        .set_i(flim_set),
        .wr_i (err_wr_i),
        .w1c_i(flim_w1c_i),
        .err_o(flim_err_o)
    );

    brl_sticky #(.N(NCH)) i_fwdg (
        .clk  (clk),
        .rst  (rst),
        .set_i(fwdg_set),
        .wr_i (err_wr_i),
        .w1c_i(fwdg_w1c_i),
        .err_o(fwdg_err_o)
    );

    // R6
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (flim_set & fwdg_set) == '0);

    // R4
    no_burst_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_code_i[5:2] < 4'd4) |-> (fwdg_set == '0));

endmodule

// File: tb/test_brl_rate_limiter.sv
module test_brl_rate_limiter;
    localparam int NCH = 2;
    localparam int GC = 8, GL = 4, GS = 2;
    localparam int WL = 4, WS = 3, TL = 12, TS = 9, DL = 5, DS = 3;
    localparam int GMAX = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NCH-1:0] req = '0;
    logic           short_sel = 1'b0;
    logic [5:0]     hw = '0;
    logic           err_wr = 1'b0;
    logic [NCH-1:0] flim_w1c = '0, fwdg_w1c = '0;
    logic [NCH-1:0] go, flim_err, fwdg_err;

    brl_rate_limiter #(
        .NCH(NCH), .GAP_CONT(GC), .GAP_LONG(GL), .GAP_SHORT(GS),
        .WT_LONG(WL), .WT_SHORT(WS), .TH_LONG(TL), .TH_SHORT(TS),
        .DRAIN_LONG(DL), .DRAIN_SHORT(DS)
    ) i_brl_rate_limiter (
        .clk(clk), .rst(rst), .pulse_req_i(req), .short_sel_i(short_sel),
        .hw_code_i(hw), .err_wr_i(err_wr), .flim_w1c_i(flim_w1c),
        .fwdg_w1c_i(fwdg_w1c), .pulse_go_o(go), .flim_err_o(flim_err),
        .fwdg_err_o(fwdg_err)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int m_since[NCH];
    int m_lvl[NCH];
    int m_cnt;
    logic [NCH-1:0] m_go, m_flim, m_fwdg;
    string m_why[NCH];

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_since[c] = GMAX; m_lvl[c] = 0; m_why[c] = "R2";
        end
        m_cnt = 0; m_go = '0; m_flim = '0; m_fwdg = '0;
    endtask

    // Apply the current inputs for one clock and compare with the model
    task automatic step();
        bit burst;
        int gap, w, th, per;
        bit tick;
        logic [NCH-1:0] fs, ws, clr_f, clr_w;
        burst = (hw[5:2] >= 4);
        gap = !burst ? GC : (short_sel ? GS : GL);
        w   = short_sel ? WS : WL;
        th  = short_sel ? TS : TL;
        per = short_sel ? DS : DL;
        tick = (m_cnt >= per - 1);
        fs = '0; ws = '0;
        for (int c = 0; c < NCH; c++) begin
            bit acc;
            acc = 0;
            m_why[c] = "R2";
            if (req[c]) begin
                if (m_since[c] < gap) begin
                    fs[c] = 1'b1; m_why[c] = burst ? "R3" : "R4";
                end else if (burst && (m_lvl[c] + w > th)) begin
                    ws[c] = 1'b1; m_why[c] = "R5";
                end else acc = 1;
            end
            m_go[c] = acc;
            m_since[c] = acc ? 1 : ((m_since[c] + 1 > GMAX) ? GMAX : m_since[c] + 1);
            if (tick && m_lvl[c] > 0) m_lvl[c] = m_lvl[c] - 1;
            if (acc && burst) m_lvl[c] = m_lvl[c] + w;
        end
        m_cnt = tick ? 0 : m_cnt + 1;
        clr_f = err_wr ? flim_w1c : '0;
        clr_w = err_wr ? fwdg_w1c : '0;
        m_flim = (m_flim & ~clr_f) | fs;
        m_fwdg = (m_fwdg & ~clr_w) | ws;
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++)
            check({m_why[c], " go"}, int'(go[c]), int'(m_go[c]));
        check((clr_f != 0) ? "R8 flim" : "R6 flim", int'(flim_err), int'(m_flim));
        check((clr_w != 0) ? "R8 fwdg" : "R7 fwdg", int'(fwdg_err), int'(m_fwdg));
    endtask

    task automatic drive(logic [NCH-1:0] r, logic wr, logic [NCH-1:0] fc, logic [NCH-1:0] wc);
        req = r; err_wr = wr; flim_w1c = fc; fwdg_w1c = wc;
        step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive('0, 1'b0, '0, '0);
    endtask

    initial begin
        #1900000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog: actual 0 expected 1 (run completion)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: reset state
        check("R1 go", int'(go), 0);
        check("R1 flim", int'(flim_err), 0);
        check("R1 fwdg", int'(fwdg_err), 0);

        // R1: first request after reset passes
        hw = 6'b010001; short_sel = 1'b0;
        drive(2'b01, 0, '0, '0);
        check("R1 first", int'(go[0]), 1);

        // R4: version 3 code forces the continuous spacing
        idle(8);
        hw = 6'b001111;
        drive(2'b01, 0, '0, '0);
        idle(3);
        drive(2'b01, 0, '0, '0);
        check("R4 old board drop", int'(go[0]), 0);
        check("R4 old board flim", int'(flim_err[0]), 1);

        // R4: version 4.1 allows the shorter spacing
        idle(8);
        hw = 6'b010001;
        drive(2'b01, 1, 2'b11, 2'b11);
        idle(3);
        drive(2'b01, 0, '0, '0);
        check("R4 new board pass", int'(go[0]), 1);

        // R10: both channels at once, then a violation on one only
        idle(8);
        drive(2'b11, 0, '0, '0);
        check("R10 both", int'(go), 3);
        drive(2'b10, 0, '0, '0);
        check("R10 ch0 flim untouched", int'(flim_err[0]), 0);
        check("R10 ch1 flim", int'(flim_err[1]), 1);

        // R9: set and clear together on ch1 keeps the bit
        drive(2'b10, 1, 2'b10, '0);
        check("R9 set wins", int'(flim_err[1]), 1);

        // R8: zero write data keeps bits, ones clear them
        drive('0, 1, 2'b00, '0);
        check("R8 zero keeps", int'(flim_err[1]), 1);
        drive('0, 1, 2'b10, '0);
        check("R8 one clears", int'(flim_err[1]), 0);

        // R5/R7: requests every 4 cycles in long burst mode exhaust the budget
        idle(20);
        for (int i = 0; i < 10; i++) begin
            drive(2'b01, 0, '0, '0);
            idle(3);
        end
        check("R7 budget drop", int'(fwdg_err[0]), 1);
        check("R5 spacing ok", int'(flim_err[0]), 0);

        // Sweep all version codes and both widths
        lf = 16'hACE1;
        for (int v = 0; v < 64; v++) begin
            for (int s = 0; s < 2; s++) begin
                hw = 6'(v);
                short_sel = s[0];
                for (int k = 0; k < 150; k++) begin
                    logic [NCH-1:0] r;
                    int ph;
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    ph = (k / 24) % 4;
                    for (int c = 0; c < NCH; c++) begin
                        case (ph)
                            0: r[c] = lf[c] & lf[c+2] & lf[c+4];
                            1: r[c] = 1'b1;
                            2: r[c] = lf[c+8];
                            default: r[c] = ((k + c) % GL) == 0;
                        endcase
                    end
                    drive(r, lf[3:0] == 4'h0, lf[5:4], lf[7:6]);
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule